// File: doc/BRIEF.md
# Ethernet DMA Control/Status Register Bank

This block is the register bank that sits between a host's 32-bit register port and the descriptor engines of an Ethernet DMA. The host reads and writes whole words. The byte address is turned into a word index. The bank holds these registers:

- the bus mode word
- the two ring base addresses and their current-descriptor pointers
- the control word
- the interrupt enable mask
- a sticky status word

Any other word inside the bank behaves as plain storage. A fixed version code sits at its own word.

The transmit and receive engines report completion and buffer shortage through single-cycle event inputs. The bank collects these events into sticky status bits. The host clears those bits by writing ones to them. A single level interrupt output stays high while any enabled status bit is set. A write to the transmit poll word sends a one-cycle kick to the transmit engine. The ring bases and the start/enable bits of the control word are driven out for the engines to use.

Top module: `dma_csr_bank`

## Requirements
- R1: The word index is the byte address shifted right by two. The bank holds BANK_WORDS words (1024 by default). Reads of words at or above the bank size return 0. Writes to those words change nothing inside the bank.
- R2: A write to the status word (index 0x3C5) clears exactly the bits that are 1 in the written data. Every other status bit keeps its value.
- R3: A transmit-done event sets status bit 0 and bit 16. A receive-done event sets bit 6 and bit 16. A receive-no-buffer event sets bit 7 and bit 15. All of these bits take effect on the clock edge that samples the event.
- R4: If an event sets a status bit on the same edge that a host write clears it, the bit ends up set.
- R5: `irq` is high exactly while the bitwise AND of the status word and the interrupt enable word (index 0x3C7) is nonzero. It follows register changes with no extra delay.
- R6: A write to the receive base (index 0x3C3) stores the value and also loads it into the receive current-descriptor pointer (index 0x3D3). A write to the transmit base (index 0x3C4) does the same for the transmit pointer (index 0x3D2). Both bases are driven on output ports.
- R7: A write to bus mode (index 0x3C0) stores the data with bit 0 forced to 0.
- R8: A write to the transmit poll word (index 0x3C1) raises `tx_poll` for exactly the one cycle after the write edge. No data is stored, and the word reads as 0.
- R9: Index 0x008 always reads 0x00001012, whatever was written to it.
- R10: The control word (index 0x3C6) reads back as written. Bit 1 drives `rx_enable` and bit 13 drives `tx_start`.
- R11: Any other word inside the bank reads back the last value written to it.
- R12: After reset the status, control, enable, bus mode, base and pointer words are all 0, and `irq` and `tx_poll` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Write strobe for the current address |
| host_addr | input | ADDR_W | Byte address |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Combinational read data for host_addr |
| tx_done_ev | input | 1 | Transmit frame finished pulse |
| rx_done_ev | input | 1 | Receive frame stored pulse |
| rx_nobuf_ev | input | 1 | Receive found no free descriptor pulse |
| tx_poll | output | 1 | One-cycle transmit poll kick |
| rx_ring_base | output | 32 | Receive ring base address |
| tx_ring_base | output | 32 | Transmit ring base address |
| tx_start | output | 1 | Control bit 13 |
| rx_enable | output | 1 | Control bit 1 |
| irq | output | 1 | Level interrupt |

## Verification
The bench fires an event on the same edge as a host clear of that bit. A design that let the clear win would lose a completion, and the readback would show the bit low. Status clears use sparse masks, so a design that cleared the whole word would wipe bits the mask never named. The bench watches `tx_poll` on two edges: a pulse that is stretched, or stored as a register, shows up as a second high cycle or a nonzero readback. A write just above the bank must not alias onto a low word, and the version word must ignore a write to it.

// File: rtl/dmacsr_pkg.sv
package dmacsr_pkg;
  typedef logic [31:0] word_t;

  localparam int unsigned IX_VERSION = 'h008;
  localparam int unsigned IX_BUSMODE = 'h3C0;
  localparam int unsigned IX_POLL    = 'h3C1;
  localparam int unsigned IX_RXBASE  = 'h3C3;
  localparam int unsigned IX_TXBASE  = 'h3C4;
  localparam int unsigned IX_STATUS  = 'h3C5;
  localparam int unsigned IX_CTRL    = 'h3C6;
  localparam int unsigned IX_IEN     = 'h3C7;
  localparam int unsigned IX_CURTX   = 'h3D2;
  localparam int unsigned IX_CURRX   = 'h3D3;

  localparam int unsigned SB_TX_DONE  = 0;
  localparam int unsigned SB_RX_DONE  = 6;
  localparam int unsigned SB_RX_NOBUF = 7;
  localparam int unsigned SB_ABN_SUM  = 15;
  localparam int unsigned SB_NRM_SUM  = 16;

  localparam int unsigned CB_RX_EN = 1;
  localparam int unsigned CB_TX_GO = 13;

  typedef struct packed {
    logic bank;
    logic version;
    logic busmode;
    logic poll;
    logic rxbase;
    logic txbase;
    logic status;
    logic ctrl;
    logic ien;
    logic curtx;
    logic currx;
  } sel_t;

  function automatic word_t sticky_next(word_t cur, word_t clr, word_t set);
    return (cur & ~clr) | set;
  endfunction

  function automatic logic irq_level(word_t st, word_t en);
    return |(st & en);
  endfunction

  function automatic word_t event_bits(logic txd, logic rxd, logic nobuf);
    word_t v;
    v = '0;
    v[SB_TX_DONE]  = txd;
    v[SB_RX_DONE]  = rxd;
    v[SB_NRM_SUM]  = txd | rxd;
    v[SB_RX_NOBUF] = nobuf;
    v[SB_ABN_SUM]  = nobuf;
    return v;
  endfunction
endpackage

// File: rtl/dmacsr_decode.sv
module dmacsr_decode
  import dmacsr_pkg::*;
#(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned BANK_WORDS = 1024,
  localparam int unsigned IDX_W     = $clog2(BANK_WORDS)
) (
  input  logic [ADDR_W-1:0] addr,
  output sel_t              sel,
  output logic [IDX_W-1:0]  idx
);
  localparam logic [ADDR_W-3:0] WORD_LIM = (ADDR_W-2)'(BANK_WORDS);

  logic [ADDR_W-3:0] word;
  logic              in_bank;
  logic              unused_lsb;

  assign word       = addr[ADDR_W-1:2];
  assign unused_lsb = ^addr[1:0];
  assign in_bank    = (word < WORD_LIM);
  assign idx        = word[IDX_W-1:0];

  always_comb begin
    sel         = '0;
    sel.bank    = in_bank;
    sel.version = in_bank && (idx == IDX_W'(IX_VERSION));
    sel.busmode = in_bank && (idx == IDX_W'(IX_BUSMODE));
    sel.poll    = in_bank && (idx == IDX_W'(IX_POLL));
    sel.rxbase  = in_bank && (idx == IDX_W'(IX_RXBASE));
    sel.txbase  = in_bank && (idx == IDX_W'(IX_TXBASE));
    sel.status  = in_bank && (idx == IDX_W'(IX_STATUS));
    sel.ctrl    = in_bank && (idx == IDX_W'(IX_CTRL));
    sel.ien     = in_bank && (idx == IDX_W'(IX_IEN));
    sel.curtx   = in_bank && (idx == IDX_W'(IX_CURTX));
    sel.currx   = in_bank && (idx == IDX_W'(IX_CURRX));
  end
endmodule

// File: rtl/dmacsr_status.sv
module dmacsr_status
  import dmacsr_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  word_t clr_vec,
  input  word_t set_vec,
  output word_t status_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= sticky_next(status_q, clr_vec, set_vec);
  end
endmodule

// File: rtl/dmacsr_scratch.sv
module dmacsr_scratch
  import dmacsr_pkg::*;
#(
  parameter int unsigned BANK_WORDS = 1024,
  localparam int unsigned IDX_W     = $clog2(BANK_WORDS)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] idx,
  input  word_t            wdata,
  output word_t            rdata
);
  word_t mem [BANK_WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wdata;
  end

  assign rdata = mem[idx];
endmodule

// File: rtl/dma_csr_bank.sv
module dma_csr_bank
  import dmacsr_pkg::*;
#(
  parameter int unsigned ADDR_W       = 16,
  parameter int unsigned BANK_WORDS   = 1024,
  parameter logic [31:0] VERSION_CODE = 32'h0000_1012
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [31:0]       host_wdata,
  output logic [31:0]       host_rdata,
  input  logic              tx_done_ev,
  input  logic              rx_done_ev,
  input  logic              rx_nobuf_ev,
  output logic              tx_poll,
  output logic [31:0]       rx_ring_base,
  output logic [31:0]       tx_ring_base,
  output logic              tx_start,
  output logic              rx_enable,
  output logic              irq
);
  localparam int unsigned IDX_W = $clog2(BANK_WORDS);

  sel_t             sel;
  logic [IDX_W-1:0] idx;
  word_t            scratch_rd;
  word_t            status_q;
  word_t            busmode_q, rxbase_q, txbase_q, ctrl_q, ien_q;
  word_t            tx_cur_q, rx_cur_q;
  logic             poll_q;

  // named internal events for the checker
  logic  wr_busmode, wr_poll, wr_rxbase, wr_txbase, wr_status;
  logic  wr_ctrl, wr_ien, wr_curtx, wr_currx, wr_scratch;
  word_t ev_set_vec, host_clr_vec;

  dmacsr_decode #(.ADDR_W(ADDR_W), .BANK_WORDS(BANK_WORDS)) u_dec (
    .addr (host_addr),
    .sel  (sel),
    .idx  (idx)
  );

  assign wr_busmode = host_wr && sel.busmode;
  assign wr_poll    = host_wr && sel.poll;
  assign wr_rxbase  = host_wr && sel.rxbase;
  assign wr_txbase  = host_wr && sel.txbase;
  assign wr_status  = host_wr && sel.status;
  assign wr_ctrl    = host_wr && sel.ctrl;
  assign wr_ien     = host_wr && sel.ien;
  assign wr_curtx   = host_wr && sel.curtx;
  assign wr_currx   = host_wr && sel.currx;
  assign wr_scratch = host_wr && sel.bank;

  assign ev_set_vec   = event_bits(tx_done_ev, rx_done_ev, rx_nobuf_ev);
  assign host_clr_vec = wr_status ? host_wdata : '0;

  dmacsr_status u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_vec  (host_clr_vec),
    .set_vec  (ev_set_vec),
    .status_q (status_q)
  );

  dmacsr_scratch #(.BANK_WORDS(BANK_WORDS)) u_mem (
    .clk   (clk),
    .we    (wr_scratch),
    .idx   (idx),
    .wdata (host_wdata),
    .rdata (scratch_rd)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busmode_q <= '0;
      rxbase_q  <= '0;
      txbase_q  <= '0;
      ctrl_q    <= '0;
      ien_q     <= '0;
      tx_cur_q  <= '0;
      rx_cur_q  <= '0;
      poll_q    <= 1'b0;
    end else begin
      poll_q <= wr_poll;
      if (wr_busmode) busmode_q <= host_wdata & ~word_t'(1);
      if (wr_ctrl)    ctrl_q    <= host_wdata;
      if (wr_ien)     ien_q     <= host_wdata;
      if (wr_rxbase) begin
        rxbase_q <= host_wdata;
        rx_cur_q <= host_wdata;
      end else if (wr_currx) begin
        rx_cur_q <= host_wdata;
      end
      if (wr_txbase) begin
        txbase_q <= host_wdata;
        tx_cur_q <= host_wdata;
      end else if (wr_curtx) begin
        tx_cur_q <= host_wdata;
      end
    end
  end

  always_comb begin
    if (!sel.bank)        host_rdata = '0;
    else if (sel.version) host_rdata = VERSION_CODE;
    else if (sel.busmode) host_rdata = busmode_q;
    else if (sel.poll)    host_rdata = '0;
    else if (sel.rxbase)  host_rdata = rxbase_q;
    else if (sel.txbase)  host_rdata = txbase_q;
    else if (sel.status)  host_rdata = status_q;
    else if (sel.ctrl)    host_rdata = ctrl_q;
    else if (sel.ien)     host_rdata = ien_q;
    else if (sel.curtx)   host_rdata = tx_cur_q;
    else if (sel.currx)   host_rdata = rx_cur_q;
    else                  host_rdata = scratch_rd;
  end

  assign tx_poll      = poll_q;
  assign rx_ring_base = rxbase_q;
  assign tx_ring_base = txbase_q;
  assign tx_start     = ctrl_q[CB_TX_GO];
  assign rx_enable    = ctrl_q[CB_RX_EN];
  assign irq          = irq_level(status_q, ien_q);
endmodule

// File: rtl/dmacsr_checker.sv
module dmacsr_checker
  import dmacsr_pkg::*;
(
  input logic  clk,
  input logic  rst_n,
  input word_t host_wdata,
  input logic  irq,
  input logic  tx_poll,
  input word_t status_q,
  input word_t busmode_q,
  input word_t tx_cur_q,
  input word_t rx_cur_q,
  input word_t ev_set_vec,
  input logic  wr_status,
  input logic  wr_ien,
  input logic  wr_txbase,
  input logic  wr_rxbase,
  input logic  wr_poll
);
  a_r2_w1c_exact: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_status && ev_set_vec == '0) |=> status_q == ($past(status_q) & ~$past(host_wdata)));

  a_r4_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_set_vec != '0) |=> ((status_q & $past(ev_set_vec)) == $past(ev_set_vec)));

  a_r5_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(ev_set_vec != '0 || wr_ien));

  a_r5_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q == '0) |-> !irq);

  a_r6_tx_reload: assert property (@(posedge clk) disable iff (!rst_n)
    wr_txbase |=> tx_cur_q == $past(host_wdata));

  a_r6_rx_reload: assert property (@(posedge clk) disable iff (!rst_n)
    wr_rxbase |=> rx_cur_q == $past(host_wdata));

  a_r7_reset_bit_low: assert property (@(posedge clk) disable iff (!rst_n)
    !busmode_q[0]);

  a_r8_poll_source: assert property (@(posedge clk) disable iff (!rst_n)
    tx_poll |-> $past(wr_poll));
endmodule

bind dma_csr_bank dmacsr_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .host_wdata (host_wdata),
  .irq        (irq),
  .tx_poll    (tx_poll),
  .status_q   (status_q),
  .busmode_q  (busmode_q),
  .tx_cur_q   (tx_cur_q),
  .rx_cur_q   (rx_cur_q),
  .ev_set_vec (ev_set_vec),
  .wr_status  (wr_status),
  .wr_ien     (wr_ien),
  .wr_txbase  (wr_txbase),
  .wr_rxbase  (wr_rxbase),
  .wr_poll    (wr_poll)
);

// File: tb/dma_csr_bank_test.sv
module dma_csr_bank_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0;
  logic [15:0] host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        tx_done_ev = 1'b0, rx_done_ev = 1'b0, rx_nobuf_ev = 1'b0;
  logic        tx_poll, tx_start, rx_enable, irq;
  logic [31:0] rx_ring_base, tx_ring_base;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dma_csr_bank uut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .tx_done_ev(tx_done_ev), .rx_done_ev(rx_done_ev), .rx_nobuf_ev(rx_nobuf_ev),
    .tx_poll(tx_poll), .rx_ring_base(rx_ring_base), .tx_ring_base(tx_ring_base),
    .tx_start(tx_start), .rx_enable(rx_enable), .irq(irq)
  );

  function automatic logic [15:0] ba(int unsigned w);
    return 16'(w << 2);
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [15:0] a, logic [31:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd(logic [15:0] a, output logic [31:0] d);
    @(negedge clk);
    host_addr = a;
    #1 d = host_rdata;
  endtask

  task automatic fire(logic t, logic r, logic n);
    @(negedge clk);
    tx_done_ev = t; rx_done_ev = r; rx_nobuf_ev = n;
    @(negedge clk);
    tx_done_ev = 0; rx_done_ev = 0; rx_nobuf_ev = 0;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(ba('h3C5), v); check("R12 status", v, 0);
    rd(ba('h3C6), v); check("R12 ctrl", v, 0);
    rd(ba('h3C0), v); check("R12 busmode", v, 0);
    rd(ba('h3D2), v); check("R12 txcur", v, 0);
    check("R12 irq", {31'b0, irq}, 0);
    check("R12 poll", {31'b0, tx_poll}, 0);
  endtask

  task automatic t_busmode;
    logic [31:0] v;
    wr(ba('h3C0), 32'hABCD_0001);
    rd(ba('h3C0), v); check("R7 bit0 forced", v, 32'hABCD_0000);
  endtask

  task automatic t_poll;
    logic [31:0] v;
    @(negedge clk);
    host_wr = 1; host_addr = ba('h3C1); host_wdata = 32'hFFFF_FFFF;
    @(posedge clk); #1 check("R8 pulse high", {31'b0, tx_poll}, 1);
    @(negedge clk); host_wr = 0;
    @(posedge clk); #1 check("R8 pulse one cycle", {31'b0, tx_poll}, 0);
    rd(ba('h3C1), v); check("R8 not stored", v, 0);
  endtask

  task automatic t_bases;
    logic [31:0] v;
    wr(ba('h3C3), 32'h1000_0040);
    rd(ba('h3D3), v); check("R6 rx ptr reload", v, 32'h1000_0040);
    check("R6 rx base port", rx_ring_base, 32'h1000_0040);
    wr(ba('h3D2), 32'h5555_0000);
    wr(ba('h3C4), 32'h2000_0080);
    rd(ba('h3D2), v); check("R6 tx ptr reload", v, 32'h2000_0080);
    check("R6 tx base port", tx_ring_base, 32'h2000_0080);
    rd(ba('h3D3), v); check("R6 rx ptr untouched", v, 32'h1000_0040);
  endtask

  task automatic t_events;
    logic [31:0] v;
    fire(1, 0, 0);
    rd(ba('h3C5), v); check("R3 tx done", v, 32'h0001_0001);
    fire(0, 1, 1);
    rd(ba('h3C5), v); check("R3 rx+nobuf", v, 32'h0001_80C1);
  endtask

  task automatic t_w1c;
    logic [31:0] v;
    wr(ba('h3C5), 32'h0000_0081);
    rd(ba('h3C5), v); check("R2 partial clear", v, 32'h0001_8040);
    wr(ba('h3C5), 32'hFFFF_FFFF);
    rd(ba('h3C5), v); check("R2 full clear", v, 0);
  endtask

  task automatic t_priority;
    logic [31:0] v;
    fire(1, 0, 0);
    @(negedge clk);
    host_wr = 1; host_addr = ba('h3C5); host_wdata = 32'h0001_0001; tx_done_ev = 1;
    @(negedge clk);
    host_wr = 0; tx_done_ev = 0;
    rd(ba('h3C5), v); check("R4 event beats clear", v, 32'h0001_0001);
    wr(ba('h3C5), 32'hFFFF_FFFF);
  endtask

  task automatic t_irq;
    wr(ba('h3C7), 32'h0000_0080);
    check("R5 idle low", {31'b0, irq}, 0);
    fire(1, 0, 0);
    check("R5 masked event", {31'b0, irq}, 0);
    fire(0, 0, 1);
    check("R5 enabled high", {31'b0, irq}, 1);
    wr(ba('h3C5), 32'h0000_0080);
    check("R5 low after clear", {31'b0, irq}, 0);
    wr(ba('h3C7), 32'h0000_0001);
    check("R5 enable existing bit", {31'b0, irq}, 1);
    wr(ba('h3C5), 32'hFFFF_FFFF);
    check("R5 cleared", {31'b0, irq}, 0);
  endtask

  task automatic t_version;
    logic [31:0] v;
    wr(ba('h008), 32'hDEAD_BEEF);
    rd(ba('h008), v); check("R9 version", v, 32'h0000_1012);
  endtask

  task automatic t_ctrl;
    logic [31:0] v;
    wr(ba('h3C6), 32'h0000_2002);
    rd(ba('h3C6), v); check("R10 ctrl readback", v, 32'h0000_2002);
    check("R10 outputs both", {30'b0, tx_start, rx_enable}, 2'b11);
    wr(ba('h3C6), 32'h0000_0002);
    check("R10 outputs rx only", {30'b0, tx_start, rx_enable}, 2'b01);
  endtask

  task automatic t_scratch;
    logic [31:0] v;
    wr(ba('h001), 32'h1234_5678);
    wr(ba('h3FF), 32'hCAFE_F00D);
    rd(ba('h001), v); check("R11 scratch low", v, 32'h1234_5678);
    rd(ba('h3FF), v); check("R11 scratch top", v, 32'hCAFE_F00D);
  endtask

  task automatic t_outside;
    logic [31:0] v;
    wr(ba('h401), 32'h9999_9999);
    rd(ba('h401), v); check("R1 outside reads 0", v, 0);
    rd(ba('h001), v); check("R1 no alias", v, 32'h1234_5678);
    rd(ba('h001) | 16'h3, v); check("R1 byte lsbs ignored", v, 32'h1234_5678);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_busmode();
    t_poll();
    t_bases();
    t_events();
    t_w1c();
    t_priority();
    t_irq();
    t_version();
    t_ctrl();
    t_scratch();
    t_outside();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #800000;
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule